// File: doc/BRIEF.md
# Four-Instruction Register/Memory Processor Core

This block is a single-cycle 32-bit processor core that runs a very small subset of a classic three-operand RISC instruction set: register add, register subtract, load word and store word. Each clock cycle fetches one instruction from an internal word memory, decodes it, reads up to two registers from a 32-entry register file and executes it. An add or subtract writes its result back to a register. A load or store forms its address from a base register and a sign-extended 16-bit offset, then moves one word between the register file and an internal data memory.

The core is held frozen while `rst` is high. During that time a loader port writes words into either the instruction memory or the data memory. When reset is released, execution starts at address 0. A debug port reads the data memory at any time. The core asserts `retire` combinationally in every cycle in which the current instruction completes. A sticky `halted` flag stops the core on an undecodable instruction. A sticky `misaligned` flag records a load or store whose address is not word aligned.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high, `retire` is 0. On release, the PC is 0, all registers are 0, and `halted` and `misaligned` are 0. The loader port writes memory only in cycles where `rst` is high; a loader write with `rst` low has no effect.
- R2: A word with op (bits 31:26) = 0 and funct (bits 5:0) = 32 is an add. It writes reg[rs] + reg[rt] into rd, where rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11. Bits 10:6 are ignored.
- R3: A word with op 0 and funct 34 is a subtract. It writes reg[rs] − reg[rt], modulo 2^32, into rd.
- R4: Op 35 is load word. It writes into rt the memory word at byte address reg[rs] + sign-extended imm, where imm is bits 15:0. Negative offsets reach lower addresses.
- R5: Op 43 is store word. It writes reg[rt] to the memory word at reg[rs] + sign-extended imm. Add and subtract never change data memory.
- R6: Register 0 always reads as zero. Writes whose destination is register 0 are discarded.
- R7: Memory is byte addressed with 4-byte big-endian words, so byte address 4k is the start of word k. The word index is taken modulo the memory depth. The debug port returns the word that contains `dbg_addr`, ignoring bits 1:0.
- R8: A load or store whose effective address has bits 1:0 nonzero performs no memory write and no register write. It still retires and sets `misaligned`, which stays set until reset.
- R9: Any other op, or op 0 with any other funct (including funct 0), sets `halted` without retiring. The PC, the registers and the memory then stay unchanged until reset, and `retire` stays 0.
- R10: Each retired instruction advances the PC by 4, and `retire` is 1 for exactly those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables the loader |
| ld_we | input | 1 | Loader write enable |
| ld_dmem | input | 1 | Loader target: 1 selects data memory, 0 selects instruction memory |
| ld_addr | input | 32 | Loader byte address |
| ld_wdata | input | 32 | Loader write word |
| dbg_addr | input | 32 | Debug read byte address into data memory |
| dbg_rdata | output | 32 | Data memory word at `dbg_addr` |
| retire | output | 1 | Current instruction completes this cycle |
| halted | output | 1 | Sticky stop on an undecodable instruction |
| misaligned | output | 1 | Sticky flag for an unaligned load or store |

## Verification
The first program loads a base register, loads through positive and negative offsets, subtracts, and stores the result. This checks that address formation and sign extension land on the right word and not on a neighbour. The same program also writes through register 0, issues one unaligned load and one unaligned store, and ends on an undecodable word. The stored words and the retire count then show separately whether the zero register, the suppression on misalignment, and the halt point behave as required. A second program sweeps eight operand pairs through add and subtract: zero, all ones, sign-bit and maximum-positive values, and equal operands. These pairs expose carry-out loss, wrap on borrow and any swap of operand order.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_LDW  = 6'd35;
    localparam logic [5:0] OPC_STW  = 6'd43;
    localparam logic [5:0] FN_ADD   = 6'd32;
    localparam logic [5:0] FN_SUB   = 6'd34;

    typedef enum logic [2:0] {
        K_ADD,
        K_SUB,
        K_LDW,
        K_STW,
        K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [15:0] imm;
    } dec_t;

    function automatic dec_t decode_word(input logic [XLEN-1:0] w);
        dec_t r;
        r.rs  = w[25:21];
        r.rt  = w[20:16];
        r.rd  = w[15:11];
        r.imm = w[15:0];
        case (w[31:26])
            OPC_REG: begin
                if (w[5:0] == FN_ADD)      r.kind = K_ADD;
                else if (w[5:0] == FN_SUB) r.kind = K_SUB;
                else                       r.kind = K_BAD;
            end
            OPC_LDW: r.kind = K_LDW;
            OPC_STW: r.kind = K_STW;
            default: r.kind = K_BAD;
        endcase
        return r;
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/rcore_wmem.sv
module rcore_wmem #(
    parameter int DEPTH = 64,
    parameter int NRP   = 1,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [31:0]              wdata,
    input  logic [NRP-1:0][AW-1:0]   raddr,
    output logic [NRP-1:0][31:0]     rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
    parameter int NREGS = 32,
    parameter int RAW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  ra_a,
    input  logic [RAW-1:0]  ra_b,
    output logic [31:0]     rd_a,
    output logic [31:0]     rd_b,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [31:0]     wd
);
    logic [31:0] q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) q[i] <= '0;
        end else if (we && (wa != '0)) begin
            q[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : q[ra_b];
endmodule

// File: rtl/rcore_exec.sv
module rcore_exec
    import rcore_pkg::*;
(
    input  dec_t             d,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  result,
    output logic [XLEN-1:0]  ea,
    output logic             is_mem,
    output logic             unaligned
);
    always_comb begin
        result    = (d.kind == K_SUB) ? (a - b) : (a + b);
        ea        = a + sext16(d.imm);
        is_mem    = (d.kind == K_LDW) || (d.kind == K_STW);
        unaligned = is_mem && (ea[1:0] != 2'b00);
    end
endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import rcore_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int IAW        = $clog2(IMEM_WORDS),
    parameter int DAW        = $clog2(DMEM_WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_we,
    input  logic        ld_dmem,
    input  logic [31:0] ld_addr,
    input  logic [31:0] ld_wdata,
    input  logic [31:0] dbg_addr,
    output logic [31:0] dbg_rdata,
    output logic        retire,
    output logic        halted,
    output logic        misaligned
);
    logic [31:0] pc_q;
    logic        halted_q;
    logic        mis_q;
    logic [31:0] instr;
    dec_t        d;
    logic [31:0] rs_val, rt_val, result, ea, mem_word, wb_data;
    logic        is_mem, unaligned, legal, active;
    logic        rf_we, dm_we;
    logic [4:0]  rf_wa;
    logic [DAW-1:0] dm_waddr;
    logic [31:0] dm_wdata;
    logic [1:0][31:0] dm_rdata;
    logic        unused_bits;

    rcore_wmem #(.DEPTH(IMEM_WORDS), .NRP(1)) u_imem (
        .clk   (clk),
        .we    (rst & ld_we & ~ld_dmem),
        .waddr (ld_addr[IAW+1:2]),
        .wdata (ld_wdata),
        .raddr (pc_q[IAW+1:2]),
        .rdata (instr)
    );

    assign d = decode_word(instr);

    rcore_regfile #(.NREGS(32)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (d.rs),
        .ra_b (d.rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (wb_data)
    );

    rcore_exec u_exec (
        .d         (d),
        .a         (rs_val),
        .b         (rt_val),
        .result    (result),
        .ea        (ea),
        .is_mem    (is_mem),
        .unaligned (unaligned)
    );

    always_comb begin
        legal    = (d.kind != K_BAD);
        active   = !rst && !halted_q;
        retire   = active && legal;
        rf_wa    = (d.kind == K_LDW) ? d.rt : d.rd;
        wb_data  = (d.kind == K_LDW) ? mem_word : result;
        rf_we    = retire && ((d.kind == K_ADD) || (d.kind == K_SUB) ||
                              ((d.kind == K_LDW) && !unaligned));
        if (rst) begin
            dm_we    = ld_we && ld_dmem;
            dm_waddr = ld_addr[DAW+1:2];
            dm_wdata = ld_wdata;
        end else begin
            dm_we    = retire && (d.kind == K_STW) && !unaligned;
            dm_waddr = ea[DAW+1:2];
            dm_wdata = rt_val;
        end
    end

    rcore_wmem #(.DEPTH(DMEM_WORDS), .NRP(2)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr ({dbg_addr[DAW+1:2], ea[DAW+1:2]}),
        .rdata (dm_rdata)
    );

    assign mem_word  = dm_rdata[0];
    assign dbg_rdata = dm_rdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
            mis_q    <= 1'b0;
        end else if (active) begin
            if (!legal) begin
                halted_q <= 1'b1;
            end else begin
                pc_q <= pc_q + 32'd4;
                if (unaligned) mis_q <= 1'b1;
            end
        end
    end

    assign halted     = halted_q;
    assign misaligned = mis_q;

    assign unused_bits = ^{pc_q[31:IAW+2], pc_q[1:0], ea[31:DAW+2],
                           ld_addr[31:IAW+2], ld_addr[1:0], ld_addr[31:DAW+2],
                           dbg_addr[31:DAW+2], dbg_addr[1:0], is_mem};
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
    input logic        clk,
    input logic        rst,
    input logic        retire,
    input logic        halted,
    input logic        misaligned,
    input logic [31:0] pc
);
    // R1: leaving reset gives a clean start
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!halted && !misaligned && pc == 32'd0));

    // R10: a retired instruction moves the PC by one word
    p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
        retire |=> (pc == $past(pc) + 32'd4));

    // R9: without retirement the PC holds
    p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !retire |=> $stable(pc));

    // R9: halt is sticky
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R9: nothing retires once halted
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !retire);

    // R8: misalignment flag is sticky
    p_mis_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        misaligned |=> misaligned);
endmodule

bind rcore_top rcore_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .retire     (retire),
    .halted     (halted),
    .misaligned (misaligned),
    .pc         (pc_q)
);

// File: tb/rcore_top_test.sv
`timescale 1ns/1ps
module rcore_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_wdata = '0;
    logic [31:0] dbg_addr = '0;
    logic [31:0] dbg_rdata;
    logic        retire, halted, misaligned;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rcore_top uut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_wdata(ld_wdata), .dbg_addr(dbg_addr),
        .dbg_rdata(dbg_rdata), .retire(retire), .halted(halted),
        .misaligned(misaligned)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(bit to_d, int baddr, logic [31:0] w);
        @(negedge clk);
        ld_we = 1'b1; ld_dmem = to_d; ld_addr = baddr; ld_wdata = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic peek(int baddr, output logic [31:0] w);
        dbg_addr = baddr;
        #0.5;
        w = dbg_rdata;
    endtask

    task automatic run_prog(output int nret, output int mis_at);
        nret = 0; mis_at = -1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int c = 0; c < 1000; c++) begin
            if (misaligned && mis_at < 0) mis_at = nret;
            if (halted) break;
            if (retire) nret++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] w;
        int nret, mis_at;
        logic [31:0] opa [8];
        logic [31:0] opb [8];

        repeat (3) @(negedge clk);
        check("R1 retire in reset", {31'd0, retire}, 32'd0);

        // program 1 data
        load(1, 0,  32'd16);
        load(1, 4,  32'd7);
        load(1, 8,  32'h12345678);
        load(1, 12, 32'hCAFE0003);
        load(1, 16, 32'hA5A5A5A5);
        load(1, 24, 32'h00001000);
        load(1, 48, 32'h00000099);
        load(1, 56, 32'h00000055);
        load(1, 60, 32'h00000066);
        load(1, 68, 32'h00000077);
        // program 1 code
        load(0, 0,  enc_i(35, 0, 3, 0));       // r3 = base 16
        load(0, 4,  enc_i(35, 0, 2, 4));       // r2 = 7
        load(0, 8,  enc_i(35, 3, 8, 8));       // r8 = mem[24]
        load(0, 12, enc_r(8, 2, 8, 34));       // r8 = r8 - r2
        load(0, 16, enc_i(43, 3, 8, 32));      // mem[48] = r8
        load(0, 20, enc_i(35, 3, 9, -4));      // r9 = mem[12]
        load(0, 24, enc_r(9, 8, 10, 32));      // r10 = r9 + r8
        load(0, 28, enc_i(43, 3, 10, -8));     // mem[8] = r10
        load(0, 32, enc_r(9, 9, 0, 32));       // r0 = discard
        load(0, 36, enc_i(43, 3, 0, 40));      // mem[56] = r0
        load(0, 40, enc_r(2, 9, 11, 34));      // r11 = r2 - r9
        load(0, 44, enc_i(43, 3, 11, 44));     // mem[60] = r11
        load(0, 48, enc_i(35, 3, 12, 2));      // unaligned load
        load(0, 52, enc_i(43, 3, 12, 52));     // mem[68] = r12
        load(0, 56, enc_i(43, 3, 8, 1));       // unaligned store
        load(0, 60, enc_r(8, 2, 13, 33));      // undecodable

        run_prog(nret, mis_at);
        check("R10 retire count", nret, 32'd15);
        check("R9 halted", {31'd0, halted}, 32'd1);
        check("R8 misaligned first after 13 retires", mis_at, 32'd13);
        peek(48, w); check("R3 R4 R5 sub result stored at base+32", w, 32'h00001000 - 32'd7);
        peek(8,  w); check("R2 R4 negative-offset load and add", w, 32'hCAFE0003 + 32'h00000FF9);
        peek(56, w); check("R6 zero register", w, 32'd0);
        peek(60, w); check("R3 subtract wrap", w, 32'd7 - 32'hCAFE0003);
        peek(68, w); check("R8 load suppressed", w, 32'd0);
        peek(16, w); check("R8 store suppressed", w, 32'hA5A5A5A5);
        peek(51, w); check("R7 debug ignores low bits", w, 32'h00000FF9);

        // halted stays quiet; loader ignored out of reset
        @(negedge clk);
        ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 48; ld_wdata = 32'hBAD0BAD0;
        @(negedge clk);
        ld_we = 1'b0;
        begin
            int extra = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk); #1;
                if (retire) extra++;
            end
            check("R9 no retire while halted", extra, 32'd0);
        end
        check("R9 still halted", {31'd0, halted}, 32'd1);
        peek(48, w); check("R1 loader ignored outside reset", w, 32'h00000FF9);

        // program 2: add/sub sweep
        @(negedge clk); rst = 1'b1;
        @(negedge clk); #1;
        check("R1 halted cleared", {31'd0, halted}, 32'd0);
        check("R1 misaligned cleared", {31'd0, misaligned}, 32'd0);
        opa[0] = 32'h0;        opb[0] = 32'h0;
        opa[1] = 32'h1;        opb[1] = 32'h1;
        opa[2] = 32'hFFFFFFFF; opb[2] = 32'h1;
        opa[3] = 32'h80000000; opb[3] = 32'h1;
        opa[4] = 32'h7FFFFFFF; opb[4] = 32'hFFFFFFFF;
        opa[5] = 32'h0;        opb[5] = 32'h80000000;
        opa[6] = 32'h12345678; opb[6] = 32'h9ABCDEF0;
        opa[7] = 32'hDEADBEEF; opb[7] = 32'hDEADBEEF;
        for (int i = 0; i < 8; i++) begin
            load(1, 8*i,     opa[i]);
            load(1, 8*i + 4, opb[i]);
            load(0, 24*i,      enc_i(35, 0, 1, 8*i));
            load(0, 24*i + 4,  enc_i(35, 0, 2, 8*i + 4));
            load(0, 24*i + 8,  enc_r(1, 2, 3, 32));
            load(0, 24*i + 12, enc_r(1, 2, 4, 34));
            load(0, 24*i + 16, enc_i(43, 0, 3, 128 + 8*i));
            load(0, 24*i + 20, enc_i(43, 0, 4, 132 + 8*i));
        end
        load(0, 192, 32'h00000000);            // op 0 funct 0: undecodable

        run_prog(nret, mis_at);
        check("R10 sweep retire count", nret, 32'd48);
        check("R8 no misalignment in sweep", mis_at, 32'hFFFFFFFF);
        check("R9 funct 0 halts", {31'd0, halted}, 32'd1);
        for (int i = 0; i < 8; i++) begin
            peek(128 + 8*i, w); check("R2 add sweep", w, opa[i] + opb[i]);
            peek(132 + 8*i, w); check("R3 sub sweep", w, opa[i] - opb[i]);
        end

        finish_up();
    end
endmodule